// File: doc/BRIEF.md
# Segmented Load/Store Address Generator

This block builds the 23-bit physical address for the load and store accesses of a 16-bit processor. It takes the two source register indices and their 16-bit values. It adds the two values into a 16-bit effective address and drops any carry. It then decides which 64KB or 32KB window of the 23-bit space the access falls in, and fills in the upper address bits for that window.

An access that names the program counter is placed in the code window. The upper bits come from the PC-high value. An access that names the stack pointer, but not the program counter, is placed in the stack window. Its upper bits come from the upper byte of the status register. Every other access is a data access. Bit 15 of the effective address picks one of two 32KB data windows, and each window takes an 8-bit bank number from its own byte of the bank register.

A 2-bit segment code travels with the address so that debug logic can see which window was chosen. An optional output register, enabled by default, retimes both outputs by one clock.

Top module: `seg_addr_gen`

## Requirements
- R1: The effective address is (value A + value B) modulo 2^16; a carry out of bit 15 never reaches address bit 16 or above.
- R2: When either source index equals 14, the segment code is 00 (code), address bits 15:0 are the effective address and bits 22:16 are pc_hi_i.
- R3: When neither source index equals 14 and either equals 13, the segment code is 01 (stack), address bits 15:0 are the effective address and bits 22:16 are status_i[14:8].
- R4: An access naming index 14 and index 13 together, in either operand position, uses the code segment.
- R5: In a data access (neither index is 13 or 14), address bits 14:0 equal effective address bits 14:0.
- R6: In a data access with effective address bit 15 set, the segment code is 10 (upper data) and address bits 22:15 are bank_i[7:0].
- R7: In a data access with effective address bit 15 clear, the segment code is 11 (lower data) and address bits 22:15 are bank_i[15:8].
- R8: With the default registered output, addr_o and seg_o show the result of the inputs present at the previous rising clock edge, and the inputs have no effect between edges. While rst_ni is low, addr_o is 0 and seg_o is 00.
- R9: status_i bit 15 and status_i bits 7:0 never affect the address, and pc_hi_i affects only code accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_a_idx_i | input | 4 | Index of the first source register |
| src_b_idx_i | input | 4 | Index of the second source register |
| src_a_val_i | input | 16 | Value of the first source register |
| src_b_val_i | input | 16 | Value of the second source register |
| pc_hi_i | input | 7 | Upper program counter bits for the code window |
| status_i | input | 16 | Status register; bits 14:8 select the stack window |
| bank_i | input | 16 | Bank register; high byte for lower data, low byte for upper data |
| addr_o | output | 23 | Physical address |
| seg_o | output | 2 | Segment code: 00 code, 01 stack, 10 upper data, 11 lower data |

## Verification
The bench uses register values whose sum carries out of bit 15. A design that kept this carry would set address bit 16 or step into the next bank. It puts the PC and SP indices together in both operand orders to catch a priority that depends on operand position, or one that favours the stack. It also builds effective addresses on both sides of 0x7FFF/0x8000, once through a carry, to expose a design that swaps the bank bytes or decides the window from an operand rather than from the sum. Junk in the unused status bits and a changing pc_hi during data accesses show up any leak of those fields into the address.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int unsigned SEG_W = 2;

  typedef enum logic [SEG_W-1:0] {
    SEG_CODE  = 2'b00,
    SEG_STACK = 2'b01,
    SEG_UDATA = 2'b10,
    SEG_LDATA = 2'b11
  } seg_e;
endpackage

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o
);
  // carry dropped: result width equals operand width
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/seg_addr_sel.sv
module seg_addr_sel
  import seg_addr_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PC_IDX = 14,
  parameter int unsigned SP_IDX = 13
) (
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic [IDX_W-1:0] b_idx_i,
  input  logic             sum_msb_i,
  output seg_e             seg_o
);
  localparam logic [IDX_W-1:0] PC_V = IDX_W'(PC_IDX);
  localparam logic [IDX_W-1:0] SP_V = IDX_W'(SP_IDX);

  logic uses_pc, uses_sp;
  assign uses_pc = (a_idx_i == PC_V) || (b_idx_i == PC_V);
  assign uses_sp = (a_idx_i == SP_V) || (b_idx_i == SP_V);

  always_comb begin
    if (uses_pc)        seg_o = SEG_CODE;   // code beats stack
    else if (uses_sp)   seg_o = SEG_STACK;
    else if (sum_msb_i) seg_o = SEG_UDATA;
    else                seg_o = SEG_LDATA;
  end
endmodule

// File: rtl/seg_addr_compose.sv
module seg_addr_compose
  import seg_addr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 23
) (
  input  logic [DATA_W-1:0]        sum_i,
  input  seg_e                     seg_i,
  input  logic [ADDR_W-DATA_W-1:0] pc_hi_i,
  input  logic [ADDR_W-DATA_W-1:0] stk_hi_i,
  input  logic [DATA_W-1:0]        bank_i,
  output logic [ADDR_W-1:0]        addr_o
);
  localparam int unsigned OFF_W  = DATA_W - 1;
  localparam int unsigned BANK_W = ADDR_W - OFF_W;

  logic [BANK_W-1:0] bank_up, bank_lo;
  assign bank_up = bank_i[BANK_W-1:0];
  assign bank_lo = bank_i[DATA_W-1 -: BANK_W];

  always_comb begin
    unique case (seg_i)
      SEG_CODE:  addr_o = {pc_hi_i, sum_i};
      SEG_STACK: addr_o = {stk_hi_i, sum_i};
      SEG_UDATA: addr_o = {bank_up, sum_i[OFF_W-1:0]};
      default:   addr_o = {bank_lo, sum_i[OFF_W-1:0]};
    endcase
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 23,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned PC_IDX  = 14,
  parameter int unsigned SP_IDX  = 13,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IDX_W-1:0]         src_a_idx_i,
  input  logic [IDX_W-1:0]         src_b_idx_i,
  input  logic [DATA_W-1:0]        src_a_val_i,
  input  logic [DATA_W-1:0]        src_b_val_i,
  input  logic [ADDR_W-DATA_W-1:0] pc_hi_i,
  input  logic [DATA_W-1:0]        status_i,
  input  logic [DATA_W-1:0]        bank_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [SEG_W-1:0]         seg_o
);
  localparam int unsigned HI_W   = ADDR_W - DATA_W;
  localparam int unsigned OFF_W  = DATA_W - 1;
  localparam int unsigned BANK_W = ADDR_W - OFF_W;
  localparam logic [IDX_W-1:0] PC_V = IDX_W'(PC_IDX);
  localparam logic [IDX_W-1:0] SP_V = IDX_W'(SP_IDX);

  logic [DATA_W-1:0] sum_w;
  logic [HI_W-1:0]   stk_hi_w;
  seg_e              seg_w;
  logic [ADDR_W-1:0] addr_w;

  assign stk_hi_w = status_i[DATA_W-2 -: HI_W];
  logic unused_status;
  assign unused_status = ^{status_i[DATA_W-1], status_i[DATA_W-HI_W-2:0]};

  seg_addr_add #(.DATA_W(DATA_W)) u_add (
    .a_i   (src_a_val_i),
    .b_i   (src_b_val_i),
    .sum_o (sum_w)
  );

  seg_addr_sel #(.IDX_W(IDX_W), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX)) u_sel (
    .a_idx_i   (src_a_idx_i),
    .b_idx_i   (src_b_idx_i),
    .sum_msb_i (sum_w[DATA_W-1]),
    .seg_o     (seg_w)
  );

  seg_addr_compose #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmp (
    .sum_i    (sum_w),
    .seg_i    (seg_w),
    .pc_hi_i  (pc_hi_i),
    .stk_hi_i (stk_hi_w),
    .bank_i   (bank_i),
    .addr_o   (addr_w)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [ADDR_W-1:0] addr_q;
      seg_e              seg_q;
      logic              primed_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_q   <= '0;
          seg_q    <= SEG_CODE;
          primed_q <= 1'b0;
        end else begin
          addr_q   <= addr_w;
          seg_q    <= seg_w;
          primed_q <= 1'b1;
        end
      end
      assign addr_o = addr_q;
      assign seg_o  = seg_q;

      p_reg_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed_q |-> (addr_o == $past(addr_w) && seg_o == $past(seg_w)));
    end else begin : g_comb
      assign addr_o = addr_w;
      assign seg_o  = seg_w;
    end
  endgenerate

  p_code_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_idx_i == PC_V || src_b_idx_i == PC_V) |->
      (seg_w == SEG_CODE && addr_w[ADDR_W-1:DATA_W] == pc_hi_i));
  p_stack_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_w == SEG_STACK) |-> (addr_w[ADDR_W-1:DATA_W] == stk_hi_w
      && src_a_idx_i != PC_V && src_b_idx_i != PC_V));
  p_code_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_idx_i == SP_V && src_b_idx_i == PC_V) |-> seg_w == SEG_CODE);
  p_data_offset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_w == SEG_UDATA || seg_w == SEG_LDATA) |->
      addr_w[OFF_W-1:0] == (src_a_val_i[OFF_W-1:0] + src_b_val_i[OFF_W-1:0]));
  p_upper_bank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_w == SEG_UDATA) |-> addr_w[ADDR_W-1:OFF_W] == bank_i[BANK_W-1:0]);
  p_lower_bank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_w == SEG_LDATA) |-> addr_w[ADDR_W-1:OFF_W] == bank_i[DATA_W-1 -: BANK_W]);
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  a_idx = '0, b_idx = '0;
  logic [15:0] a_val = '0, b_val = '0;
  logic [6:0]  pc_hi = '0;
  logic [15:0] status = '0, bank = '0;
  logic [22:0] addr;
  logic [1:0]  seg;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  seg_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_a_idx_i(a_idx), .src_b_idx_i(b_idx),
    .src_a_val_i(a_val), .src_b_val_i(b_val),
    .pc_hi_i(pc_hi), .status_i(status), .bank_i(bank),
    .addr_o(addr), .seg_o(seg)
  );

  // expected model from requirements
  function automatic logic [24:0] model(input logic [3:0] ai, input logic [3:0] bi,
                                        input logic [15:0] av, input logic [15:0] bv,
                                        input logic [6:0] ph, input logic [15:0] st,
                                        input logic [15:0] bk);
    logic [15:0] s;
    s = av + bv;
    if (ai == 4'd14 || bi == 4'd14)      return {2'b00, ph, s};
    else if (ai == 4'd13 || bi == 4'd13) return {2'b01, st[14:8], s};
    else if (s[15])                      return {2'b10, bk[7:0], s[14:0]};
    else                                 return {2'b11, bk[15:8], s[14:0]};
  endfunction

  task automatic check(input string req, input logic [22:0] ea, input logic [1:0] es);
    checks++;
    if (addr !== ea || seg !== es) begin
      fails++;
      $display("FAIL %s: addr=%h seg=%b expected addr=%h seg=%b", req, addr, seg, ea, es);
    end
  endtask

  task automatic run(input string req, input logic [3:0] ai, input logic [3:0] bi,
                     input logic [15:0] av, input logic [15:0] bv);
    logic [24:0] e;
    @(negedge clk);
    a_idx = ai; b_idx = bi; a_val = av; b_val = bv;
    e = model(ai, bi, av, bv, pc_hi, status, bank);
    @(negedge clk);
    check(req, e[22:0], e[24:23]);
  endtask

  task automatic t_reset;
    check("R8 reset", 23'h0, 2'b00);
  endtask

  task automatic t_code;
    pc_hi = 7'h5A;
    run("R2 code a", 4'd14, 4'd3, 16'h1234, 16'h0100);
    run("R2 code b", 4'd2, 4'd14, 16'h0042, 16'h0008);
    run("R1 code carry", 4'd14, 4'd1, 16'hFFF0, 16'h0020);
    check("R1 carry bit16 clear", {7'h5A, 16'h0010}, 2'b00);
  endtask

  task automatic t_stack;
    status = 16'h3300;
    run("R3 stack", 4'd13, 4'd5, 16'h8000, 16'h0004);
    status = 16'hB3FF; // bit15 and low byte junk
    run("R9 status junk", 4'd6, 4'd13, 16'h8000, 16'h0004);
    check("R9 stack hi=33", {7'h33, 16'h8004}, 2'b01);
    run("R1 stack carry", 4'd13, 4'd0, 16'hFFFF, 16'h0002);
  endtask

  task automatic t_priority;
    run("R4 pc+sp", 4'd14, 4'd13, 16'h0010, 16'h0020);
    run("R4 sp+pc", 4'd13, 4'd14, 16'h0010, 16'h0020);
  endtask

  task automatic t_data;
    bank = 16'hC3_5E;
    run("R6 upper", 4'd1, 4'd2, 16'h8000, 16'h0123);
    run("R7 lower", 4'd1, 4'd2, 16'h7FFF, 16'h0000);
    check("R7 lower value", {8'hC3, 15'h7FFF}, 2'b11);
    run("R6 boundary carry", 4'd3, 4'd4, 16'h7FFF, 16'h0001);
    check("R6 boundary value", {8'h5E, 15'h0000}, 2'b10);
    run("R5 wrap to lower", 4'd3, 4'd4, 16'hFFFF, 16'h0003);
    check("R5 wrap value", {8'hC3, 15'h0002}, 2'b11);
    pc_hi = 7'h7F;
    run("R9 pc_hi ignored", 4'd3, 4'd4, 16'hFFFF, 16'h0003);
    check("R9 pc_hi no effect", {8'hC3, 15'h0002}, 2'b11);
    run("R6 r12 upper", 4'd12, 4'd0, 16'hABCD, 16'h0000);
    run("R7 r15 lower", 4'd15, 4'd11, 16'h0F00, 16'h00F0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    a_idx = 4'd14; b_idx = 4'd0; a_val = 16'h0001; b_val = 16'h0000; pc_hi = 7'h01;
    #2;
    check("R8 hold before edge", {8'hC3, 15'h00F0 + 15'h0F00}, 2'b11);
    @(negedge clk);
    check("R8 update after edge", {7'h01, 16'h0001}, 2'b00);
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_code();
    t_stack();
    t_priority();
    t_data();
    t_latency();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async reset", 23'h0, 2'b00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule